// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the address for each beat of a four-beat memory burst. When a burst starts, it captures a full start address. After that, each advance strobe moves the two least significant bits to the next beat position. The bits above those two stay exactly as they were captured. A memory array or cache port can place the block in front of its address decoder and step it once for each data beat.

Two beat orders are available. The order is selected at the start of each burst and stays fixed until the next start:

- **Interleaved order:** each beat's low bits are the start low bits XORed with the beat number.
- **Linear order:** the low bits count up modulo four from the start position. The start position can be any of the four.

After the fourth beat, the sequence wraps back to its first address.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, and before the first load, `addr_o` is all zeros and the order is interleaved.
- R2: On a clock edge where `load_i` is 1, `addr_o` becomes `start_addr_i` from that edge and the beat number becomes 0.
- R3: On an edge where `load_i` is 0 and `adv_n_i` is 1, `addr_o` keeps its value.
- R4: When `mode_i` was 1 at the load (interleaved), `addr_o[1:0]` on beat n is the start low bits XOR n. Start 01 gives 01, 00, 11, 10.
- R5: When `mode_i` was 0 at the load (linear), `addr_o[1:0]` on beat n is (start low bits + n) mod 4. Start 10 gives 10, 11, 00, 01.
- R6: The beat number advances by one, modulo 4, only on edges where `load_i` is 0 and `adv_n_i` is 0. The fifth address of a burst therefore equals the first.
- R7: `addr_o[ADDR_W-1:2]` never changes on an edge without a load.
- R8: When `load_i` is 1 and `adv_n_i` is 0 on the same edge, the load wins: `addr_o` equals `start_addr_i`, not an advanced address.
- R9: `mode_i` is sampled only on load edges. Changing it in the middle of a burst has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Starts a burst at `start_addr_i` |
| start_addr_i | input | ADDR_W | First address of the burst |
| adv_n_i | input | 1 | Advance strobe, active low |
| mode_i | input | 1 | Beat order: 1 = interleaved, 0 = linear |
| addr_o | output | ADDR_W | Address of the current beat |

## Verification
The properties assume that all inputs are free of X after reset. They also follow the burst order by keeping their own copy of `mode_i`, captured on load edges. The per-step checks therefore depend on the assumption that a burst's order is the one latched at its load. The stimulus drives every input to a defined 0 or 1 on the falling edge and never leaves them undriven. Random cycles let `mode_i` toggle freely, which exercises the claim that only load edges sample it.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int unsigned BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int unsigned BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              step_i,
    output logic [BEAT_W-1:0] beat_o
);
    typedef struct packed {
        logic [BEAT_W-1:0] beat;
    } ctr_s;

    ctr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.beat = '0;
        end else if (step_i) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_o = st_q.beat;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int unsigned BEAT_W = 2
) (
    input  logic [BEAT_W-1:0]    start_i,
    input  logic [BEAT_W-1:0]    beat_i,
    input  burst_seq_pkg::order_e order_i,
    output logic [BEAT_W-1:0]    low_o
);
    logic [BEAT_W-1:0] xor_pos;
    logic [BEAT_W-1:0] lin_pos;
    logic [BEAT_W:0]   carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < BEAT_W; i++) begin : g_bit
        assign xor_pos[i]  = start_i[i] ^ beat_i[i];
        assign lin_pos[i]  = start_i[i] ^ beat_i[i] ^ carry[i];
        assign carry[i+1]  = (start_i[i] & beat_i[i]) | (carry[i] & (start_i[i] ^ beat_i[i]));
    end

    always_comb begin
        if (order_i == burst_seq_pkg::ORD_XOR) begin
            low_o = xor_pos;
        end else begin
            low_o = lin_pos;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] addr_o
);
    import burst_seq_pkg::*;

    localparam int unsigned LO_W = BEAT_W;
    localparam int unsigned HI_W = ADDR_W - LO_W;

    typedef struct packed {
        logic [HI_W-1:0] base_hi;
        logic [LO_W-1:0] base_lo;
        order_e          order;
    } base_s;

    base_s st_d, st_q;

    logic            step;
    logic [LO_W-1:0] beat;
    logic [LO_W-1:0] low;

    // A load takes priority over an advance on the same edge.
    assign step = !load_i && !adv_n_i;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.base_hi = start_addr_i[ADDR_W-1:LO_W];
            st_d.base_lo = start_addr_i[LO_W-1:0];
            st_d.order   = order_e'(mode_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base_hi <= '0;
            st_q.base_lo <= '0;
            st_q.order   <= ORD_XOR;
        end else begin
            st_q <= st_d;
        end
    end

    burst_beat_ctr #(.BEAT_W(LO_W)) u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load_i),
        .step_i    (step),
        .beat_o    (beat)
    );

    burst_order_map #(.BEAT_W(LO_W)) u_map (
        .start_i (st_q.base_lo),
        .beat_i  (beat),
        .order_i (st_q.order),
        .low_o   (low)
    );

    assign addr_o = {st_q.base_hi, low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              adv_n_i,
    input logic              mode_i,
    input logic [ADDR_W-1:0] addr_o
);
    logic xor_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xor_seen_q <= 1'b1;
        end else if (load_i) begin
            xor_seen_q <= mode_i;
        end
    end

    // R2, R8: a load always lands the start address
    p_load_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(start_addr_i));

    // R3: no load, no advance -> address held
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(addr_o));

    // R7: upper bits untouched between loads
    p_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

    // R5: linear step adds one
    p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && !xor_seen_q) |=> addr_o[1:0] == $past(addr_o[1:0]) + 2'd1);

    // R4: interleaved step always flips bit 0
    p_xor_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && xor_seen_q) |=> addr_o[0] != $past(addr_o[0]));

    // R6: every advance moves the low bits
    p_adv_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i) |=> addr_o[1:0] != $past(addr_o[1:0]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .start_addr_i (start_addr_i),
    .adv_n_i      (adv_n_i),
    .mode_i       (mode_i),
    .addr_o       (addr_o)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic          adv_n_i = 1'b1;
    logic          mode_i = 1'b0;
    logic [AW-1:0] addr_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Bench model of the requirements
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    bit            m_xor  = 1'b1;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .start_addr_i (start_addr_i),
        .adv_n_i      (adv_n_i),
        .mode_i       (mode_i),
        .addr_o       (addr_o)
    );

    function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] n, bit ilv);
        return ilv ? (s ^ n) : (s + n);
    endfunction

    function automatic logic [AW-1:0] exp_addr();
        return {m_base[AW-1:2], exp_low(m_base[1:0], m_beat, m_xor)};
    endfunction

    task automatic check(string tag, logic [AW-1:0] exp);
        total++;
        if (addr_o !== exp) begin
            bad++;
            $display("FAIL %s: addr_o=%h expected=%h", tag, addr_o, exp);
        end
    endtask

    task automatic cyc(bit ld, logic [AW-1:0] a, bit advn, bit md, string tag);
        @(negedge clk);
        load_i = ld; start_addr_i = a; adv_n_i = advn; mode_i = md;
        @(posedge clk);
        if (ld) begin
            m_base = a; m_beat = 2'd0; m_xor = md;
        end else if (!advn) begin
            m_beat = m_beat + 2'd1;
        end
        #2;
        check(tag, exp_addr());
    endtask

    initial begin : watchdog
        #(8 * 100000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: addr_o=%h expected=completion", addr_o);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h00c0ffee));
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset", '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: interleaved from zero before any load
        cyc(0, '0, 0, 0, "R1 adv before load");
        check("R1 adv before load value", 17'h00001);

        // R4, R6: interleaved start 00
        cyc(1, 17'h1abc0, 1, 1, "R2 load");
        for (int i = 0; i < 4; i++) cyc(0, '0, 0, 1, "R4 xor from 00");
        check("R6 wrap to first", 17'h1abc0);

        // R4: start 01 -> 01 00 11 10
        cyc(1, 17'h05551, 1, 1, "R2 load");
        cyc(0, '0, 0, 1, "R4 xor from 01");
        check("R4 second beat is 00", 17'h05550);
        cyc(0, '0, 0, 1, "R4 xor from 01");
        check("R4 third beat is 11", 17'h05553);

        // R5: linear start 10 -> 10 11 00 01, R7 upper kept
        cyc(1, 17'h0fff6, 1, 0, "R2 load");
        cyc(0, '0, 0, 0, "R5 linear");
        check("R5 second beat 11", 17'h0fff7);
        cyc(0, '0, 0, 0, "R5 linear");
        check("R7 upper kept on wrap", 17'h0fff4);
        cyc(0, '0, 0, 0, "R5 linear");
        cyc(0, '0, 0, 0, "R6 linear wrap");
        check("R6 back to start", 17'h0fff6);

        // R3: hold with advance deasserted
        cyc(0, 17'h1ffff, 1, 1, "R3 hold");
        check("R3 held", 17'h0fff6);

        // R8: load beats advance
        cyc(0, '0, 0, 0, "R5 linear");
        cyc(1, 17'h12343, 0, 1, "R8 load over adv");
        check("R8 exact start", 17'h12343);

        // R9: mode toggled mid-burst ignored
        cyc(0, '0, 0, 0, "R9 mode change ignored");
        check("R9 still xor", 17'h12342);
        cyc(0, '0, 0, 0, "R9 mode change ignored");
        check("R9 still xor beat2", 17'h12341);

        // Random mix
        for (int k = 0; k < 2000; k++) begin
            bit ld;
            bit advn;
            bit md;
            logic [AW-1:0] a;
            string tag;
            ld   = ($urandom % 5) == 0;
            advn = ($urandom % 3) == 0;
            md   = $urandom % 2;
            a    = AW'($urandom);
            if (ld) tag = advn ? "R2 random load" : "R8 random load+adv";
            else if (advn) tag = "R3 random hold";
            else tag = m_xor ? "R4 random xor step" : "R5 random linear step";
            cyc(ld, a, advn, md, tag);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule